// File: doc/BRIEF.md
# Dual-Clock FIFO Status Flag Generator

This block derives the status outputs of a dual-clock FIFO from two event strobes: one pulse per accepted write on the write clock and one per accepted read on the read clock. It keeps a binary pointer in each domain and passes a Gray-coded copy of each pointer to the other domain through a two-flop synchroniser. From these it produces five active-low flags: full (or input-ready), empty (or output-ready), programmable almost-full, programmable almost-empty and half-full. The storage array and the data path sit outside the block.

A mode input selects standard accounting or first-word-fall-through accounting. In the second mode one extra word sits in the output register, so the capacity becomes depth plus one and every threshold moves up by one word. In that mode the full and empty pins mean "ready" when low. Each flag asserts on the edge of the clock that caused the condition. It releases only after the other side's pointer has crossed the clock boundary, so a release is always late and never early. The almost-full offset and almost-empty offset are plain inputs. The mode and both offsets are held constant while the block is out of reset.

Top module: `fifo_flag_gen`

## Requirements
- R1: While rst_ni is low: paf_n_o and hf_n_o are high and pae_n_o is low. In standard mode (mode_i=0), full_ir_o is high and empty_or_o is low. In first-word-fall-through mode (mode_i=1), full_ir_o is low and empty_or_o is high.
- R2: Capacity C is D=2**ADDR_W in standard mode and D+1 in first-word-fall-through mode. On the write-clock edge whose write brings the occupancy to C, full_ir_o goes low in standard mode and high in first-word-fall-through mode.
- R3: A write strobe while the block reports full is ignored. A read strobe while the block reports empty (not ready in first-word-fall-through mode) is ignored. Neither changes the occupancy.
- R4: paf_n_o is low exactly when the occupancy is at least C minus almost_full_off_i. It changes on the write edge that crosses the threshold.
- R5: pae_n_o is low when the occupancy is at most almost_empty_off_i in standard mode, or at most almost_empty_off_i+1 in first-word-fall-through mode. It asserts on the read edge that crosses the threshold.
- R6: hf_n_o is low when the occupancy exceeds D/2 in standard mode, or D/2+1 in first-word-fall-through mode. It goes low on the write edge that crosses the threshold.
- R7: In standard mode, empty_or_o is low exactly when the occupancy is zero. In first-word-fall-through mode, empty_or_o is low exactly when the occupancy is non-zero. Either flag moves to its empty state on the read edge that removes the last word.
- R8: After a write into an empty block, empty_or_o leaves its empty state on the 3rd read-clock edge in standard mode and on the 4th in first-word-fall-through mode. The edges are counted from the write edge.
- R9: After a read from a full block, full_ir_o leaves its full state on the 3rd write-clock edge after the read edge.

Each domain's Gray pointer changes in at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| mode_i | input | 1 | 0 = standard, 1 = first-word-fall-through; static |
| almost_full_off_i | input | ADDR_W+1 | Almost-full offset m, at most D |
| almost_empty_off_i | input | ADDR_W+1 | Almost-empty offset n |
| wr_inc_i | input | 1 | Write strobe, write clock |
| rd_inc_i | input | 1 | Read strobe, read clock |
| full_ir_o | output | 1 | Full (standard) / input-ready (fall-through), active low |
| empty_or_o | output | 1 | Empty (standard) / output-ready (fall-through), active low |
| paf_n_o | output | 1 | Almost-full, active low |
| pae_n_o | output | 1 | Almost-empty, active low |
| hf_n_o | output | 1 | Half-full, active low |

## Verification
The bench builds the block with ADDR_W=4, so D is 16 words. With that depth, capacity, both programmable thresholds and the half-full point are each reached many times within a random burst. Each mode runs after its own reset with random offsets up to D/2. The two clocks share one period but have a 3 ns phase offset. That makes the synchroniser latencies of R8 and R9 fixed edge counts that the bench can sample exactly.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } ffg_mode_e;
endpackage

// File: rtl/ffg_sync.sv
module ffg_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/ffg_gray2bin.sv
module ffg_gray2bin #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign bin_o[g] = ^(gray_i >> g);
  end
endmodule

// File: rtl/ffg_wr_side.sv
module ffg_wr_side #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwft_i,
  input  logic [ADDR_W:0]   full_off_i,
  input  logic              wr_inc_i,
  input  logic [ADDR_W+1:0] rptr_gray_i,
  output logic [ADDR_W+1:0] wptr_gray_o,
  output logic              full_o,
  output logic              paf_o,
  output logic              hf_o
);
  localparam int PTR_W = ADDR_W + 2;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] wptr_q, wptr_nx, rbin, occ_nx, cap, half_t;
  logic             full_q, paf_q, hf_q;

  ffg_gray2bin #(.W(PTR_W)) u_rconv (.gray_i(rptr_gray_i), .bin_o(rbin));

  always_comb begin
    cap     = PTR_W'(DEPTH) + PTR_W'(fwft_i);
    half_t  = PTR_W'(DEPTH / 2) + PTR_W'(fwft_i);
    wptr_nx = wptr_q + PTR_W'(wr_inc_i && !full_q);
    occ_nx  = wptr_nx - rbin;
  end

  // flags use the next pointer so assertion is same-edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q      <= '0;
      wptr_gray_o <= '0;
      full_q      <= 1'b0;
      paf_q       <= 1'b0;
      hf_q        <= 1'b0;
    end else begin
      wptr_q      <= wptr_nx;
      wptr_gray_o <= wptr_nx ^ (wptr_nx >> 1);
      full_q      <= occ_nx >= cap;
      paf_q       <= (occ_nx + PTR_W'(full_off_i)) >= cap;
      hf_q        <= occ_nx > half_t;
    end
  end

  assign full_o = full_q;
  assign paf_o  = paf_q;
  assign hf_o   = hf_q;
endmodule

// File: rtl/ffg_rd_side.sv
module ffg_rd_side #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwft_i,
  input  logic [ADDR_W:0]   empty_off_i,
  input  logic              rd_inc_i,
  input  logic [ADDR_W+1:0] wptr_gray_i,
  output logic [ADDR_W+1:0] rptr_gray_o,
  output logic              ne1_o,
  output logic              ne2_o,
  output logic              pae_o,
  output logic              hf_o
);
  localparam int PTR_W = ADDR_W + 2;
  localparam int DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] rptr_q, rptr_nx, wbin, occ_nx, pae_t, half_t;
  logic             ne1_q, ne2_q, pae_q, hf_q, rd_ok, empty_nx;

  ffg_gray2bin #(.W(PTR_W)) u_wconv (.gray_i(wptr_gray_i), .bin_o(wbin));

  always_comb begin
    rd_ok    = rd_inc_i && (fwft_i ? ne2_q : ne1_q);
    rptr_nx  = rptr_q + PTR_W'(rd_ok);
    occ_nx   = wbin - rptr_nx;
    empty_nx = occ_nx == '0;
    pae_t    = PTR_W'(empty_off_i) + PTR_W'(fwft_i);
    half_t   = PTR_W'(DEPTH / 2) + PTR_W'(fwft_i);
  end

  // ne2 adds the output-register stage; it clears with ne1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q      <= '0;
      rptr_gray_o <= '0;
      ne1_q       <= 1'b0;
      ne2_q       <= 1'b0;
      pae_q       <= 1'b1;
      hf_q        <= 1'b0;
    end else begin
      rptr_q      <= rptr_nx;
      rptr_gray_o <= rptr_nx ^ (rptr_nx >> 1);
      ne1_q       <= !empty_nx;
      ne2_q       <= ne1_q && !empty_nx;
      pae_q       <= occ_nx <= pae_t;
      hf_q        <= occ_nx > half_t;
    end
  end

  assign ne1_o = ne1_q;
  assign ne2_o = ne2_q;
  assign pae_o = pae_q;
  assign hf_o  = hf_q;
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen #(
  parameter int ADDR_W = 10
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [ADDR_W:0]   almost_full_off_i,
  input  logic [ADDR_W:0]   almost_empty_off_i,
  input  logic              wr_inc_i,
  input  logic              rd_inc_i,
  output logic              full_ir_o,
  output logic              empty_or_o,
  output logic              paf_n_o,
  output logic              pae_n_o,
  output logic              hf_n_o
);
  localparam int PTR_W = ADDR_W + 2;

  logic             fwft;
  logic [PTR_W-1:0] wptr_gray, rptr_gray, wptr_gray_rs, rptr_gray_ws;
  logic             full_w, paf_w, hf_w, ne1_r, ne2_r, pae_r, hf_r;

  assign fwft = (mode_i == ffg_pkg::MODE_FWFT);

  ffg_sync #(.W(PTR_W)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rptr_gray), .q_o(rptr_gray_ws)
  );

  ffg_sync #(.W(PTR_W)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wptr_gray), .q_o(wptr_gray_rs)
  );

  ffg_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i      (wclk_i),
    .rst_ni     (rst_ni),
    .fwft_i     (fwft),
    .full_off_i (almost_full_off_i),
    .wr_inc_i   (wr_inc_i),
    .rptr_gray_i(rptr_gray_ws),
    .wptr_gray_o(wptr_gray),
    .full_o     (full_w),
    .paf_o      (paf_w),
    .hf_o       (hf_w)
  );

  ffg_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i      (rclk_i),
    .rst_ni     (rst_ni),
    .fwft_i     (fwft),
    .empty_off_i(almost_empty_off_i),
    .rd_inc_i   (rd_inc_i),
    .wptr_gray_i(wptr_gray_rs),
    .rptr_gray_o(rptr_gray),
    .ne1_o      (ne1_r),
    .ne2_o      (ne2_r),
    .pae_o      (pae_r),
    .hf_o       (hf_r)
  );

  // ready polarity: low means "room" / "data valid" in fall-through mode
  assign full_ir_o  = fwft ? full_w : !full_w;
  assign empty_or_o = fwft ? !ne2_r : ne1_r;
  assign paf_n_o    = !paf_w;
  assign pae_n_o    = !pae_r;
  assign hf_n_o     = !(hf_w || hf_r);
endmodule

// File: rtl/ffg_checker.sv
module ffg_checker #(
  parameter int ADDR_W = 10
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              full_w,
  input logic              paf_w,
  input logic              hf_n_o,
  input logic              ne1_r,
  input logic              ne2_r,
  input logic              pae_r,
  input logic [ADDR_W+1:0] wptr_gray,
  input logic [ADDR_W+1:0] rptr_gray
);
  p_full_paf_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_w |-> paf_w);

  p_full_hf_r6: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_w |-> !hf_n_o);

  p_empty_pae_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !ne1_r |-> pae_r);

  p_ready_lag_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(ne2_r) |-> $past(ne1_r));

  p_wgray_step_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  p_rgray_step_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);
endmodule

bind fifo_flag_gen ffg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .full_w   (full_w),
  .paf_w    (paf_w),
  .hf_n_o   (hf_n_o),
  .ne1_r    (ne1_r),
  .ne2_r    (ne2_r),
  .pae_r    (pae_r),
  .wptr_gray(wptr_gray),
  .rptr_gray(rptr_gray)
);

// File: tb/fifo_flag_gen_test.sv
module fifo_flag_gen_test;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic          wclk_i = 1'b0, rclk_i = 1'b0, rst_ni = 1'b0, mode_i = 1'b0;
  logic [AW:0]   almost_full_off_i = '0, almost_empty_off_i = '0;
  logic          wr_inc_i = 1'b0, rd_inc_i = 1'b0;
  logic          full_ir_o, empty_or_o, paf_n_o, pae_n_o, hf_n_o;

  int  vectors = 0, miscompares = 0;
  int  occ = 0, cap = D, m_off = 1, n_off = 1;
  bit  fwft = 1'b0, done = 1'b0;

  fifo_flag_gen #(.ADDR_W(AW)) uut (
    .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .almost_full_off_i(almost_full_off_i), .almost_empty_off_i(almost_empty_off_i),
    .wr_inc_i(wr_inc_i), .rd_inc_i(rd_inc_i),
    .full_ir_o(full_ir_o), .empty_or_o(empty_or_o),
    .paf_n_o(paf_n_o), .pae_n_o(pae_n_o), .hf_n_o(hf_n_o)
  );

  always #10 wclk_i = ~wclk_i;
  initial begin
    #3;
    forever #10 rclk_i = ~rclk_i;
  end

  function automatic logic e_full(int o);   return fwft ? (o >= cap) : !(o >= cap); endfunction
  function automatic logic e_empty(int o);  return fwft ? (o == 0) : (o != 0); endfunction
  function automatic logic e_paf(int o);    return !(o + m_off >= cap); endfunction
  function automatic logic e_pae(int o);    return !(o <= n_off + int'(fwft)); endfunction
  function automatic logic e_hf(int o);     return !(o > D / 2 + int'(fwft)); endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s mode=%0d occ=%0d: actual %b expected %b", req, what, fwft, occ, act, exp);
    end
  endtask

  task automatic do_write();
    @(negedge wclk_i); wr_inc_i = 1'b1;
    @(negedge wclk_i); wr_inc_i = 1'b0;
    if (occ < cap) occ++;
    chk("R2", "full_ir", full_ir_o, e_full(occ));
    chk("R4", "paf_n", paf_n_o, e_paf(occ));
    chk("R6", "hf_n", hf_n_o, e_hf(occ));
  endtask

  task automatic do_read();
    @(negedge rclk_i); rd_inc_i = 1'b1;
    @(negedge rclk_i); rd_inc_i = 1'b0;
    if (occ > 0) occ--;
    chk("R7", "empty_or", empty_or_o, e_empty(occ));
    chk("R5", "pae_n", pae_n_o, e_pae(occ));
  endtask

  task automatic settle(string req);
    repeat (8) @(negedge wclk_i);
    chk(req, "settled full_ir R2", full_ir_o, e_full(occ));
    chk(req, "settled empty_or R7", empty_or_o, e_empty(occ));
    chk(req, "settled paf_n R4", paf_n_o, e_paf(occ));
    chk(req, "settled pae_n R5", pae_n_o, e_pae(occ));
    chk(req, "settled hf_n R6", hf_n_o, e_hf(occ));
  endtask

  task automatic do_reset(bit md);
    rst_ni = 1'b0;
    fwft = md; mode_i = md;
    cap = D + int'(md);
    m_off = 1 + int'($urandom % (D / 2));
    n_off = 1 + int'($urandom % (D / 2));
    almost_full_off_i = (AW + 1)'(m_off);
    almost_empty_off_i = (AW + 1)'(n_off);
    occ = 0;
    #25;
    chk("R1", "reset full_ir", full_ir_o, md ? 1'b0 : 1'b1);
    chk("R1", "reset empty_or", empty_or_o, md ? 1'b1 : 1'b0);
    chk("R1", "reset paf_n", paf_n_o, 1'b1);
    chk("R1", "reset pae_n", pae_n_o, 1'b0);
    chk("R1", "reset hf_n", hf_n_o, 1'b1);
    @(negedge wclk_i); rst_ni = 1'b1;
    repeat (2) @(negedge wclk_i);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL R1..all watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int md = 0; md < 2; md++) begin
      do_reset(md[0]);

      // R8: empty release latency counted in read-clock edges
      do_write();
      @(posedge rclk_i); #5;
      chk("R8", "empty_or after 2 rclk", empty_or_o, fwft ? 1'b1 : 1'b0);
      @(posedge rclk_i); #5;
      chk("R8", "empty_or after 3 rclk", empty_or_o, 1'b1);
      if (fwft) begin
        @(posedge rclk_i); #5;
        chk("R8", "ready after 4 rclk", empty_or_o, 1'b0);
      end
      settle("R8");
      do_read();

      // fill past capacity: extra writes must be ignored (R3)
      settle("R7");
      while (occ < cap) do_write();
      do_write();
      do_write();
      settle("R3");

      // R9: full release latency counted in write-clock edges
      do_read();
      @(posedge wclk_i);
      @(posedge wclk_i); #5;
      chk("R9", "full_ir after 2 wclk", full_ir_o, e_full(cap));
      @(posedge wclk_i); #5;
      chk("R9", "full_ir after 3 wclk", full_ir_o, e_full(cap - 1));
      settle("R9");

      // drain and over-read (R3)
      while (occ > 0) do_read();
      do_read();
      do_read();
      settle("R3");
      do_write();
      settle("R3");

      for (int r = 0; r < 20; r++) begin
        int wn, rn;
        wn = int'($urandom % (cap + 3));
        for (int k = 0; k < wn; k++) do_write();
        settle("R4");
        rn = int'($urandom % (cap + 3));
        for (int k = 0; k < rn; k++) do_read();
        settle("R5");
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule